// File: doc/BRIEF.md
# Cascaded Two-Stage Binary Counter

This block is an 8-bit up counter that wraps at 256, assembled from two identical 4-bit stages on one shared clock. The lower stage advances whenever the enable input is high. It raises a carry when it reads all ones and is enabled. The upper stage takes that carry as its own enable, so it moves exactly once per full turn of the lower stage.

A synchronous clear zeroes both stages. A parallel load writes all eight bits in one cycle. Clear wins over load, and load wins over counting. The terminal-count output flags the last count before the wrap, which lets a further counter be chained on in the same way.

Top module: `casc_counter`

## Requirements
- R1: When `clr` is 1 at a rising clock edge, `q` becomes 0 after that edge, whatever `ld` and `en` are.
- R2: When `clr` is 0 and `ld` is 1 at an edge, `q` takes the value of `ld_val` after that edge, with all eight bits written together and counting ignored.
- R3: When `clr` and `ld` are 0 and `en` is 1, `q[3:0]` steps by one modulo 16 at each edge.
- R4: The upper nibble `q[7:4]` steps by one modulo 16 only at an edge where the lower nibble read 15 and `en` was 1 (with `clr` and `ld` low), and otherwise holds.
- R5: When `clr`, `ld` and `en` are all 0, `q` keeps its value.
- R6: Taken as a whole, `q` counts modulo 256: an enabled count from 255 gives 0, and an enabled count from 15 gives 16.
- R7: `tc` is 1 exactly when `q` is 255 and `en` is 1. It is a combinational output that does not wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| ld | input | 1 | Parallel load strobe, active high |
| ld_val | input | 8 | Value written on load |
| en | input | 1 | Count enable for the lower stage |
| q | output | 8 | Counter value, upper nibble in bits 7:4 |
| tc | output | 1 | Terminal count of the whole counter |

## Verification
The assertions hold only after a first clear has been seen, because `q` has no defined value before then. They also assume that `clr`, `ld`, `ld_val` and `en` stay steady around each rising edge. The stimulus therefore starts with a clear, and it changes every input on the falling edge. After that it mixes random enables with loads of 14, 15, 254 and 255, so that both carries and the full wrap are exercised many times. Clears arrive together with `ld` and `en` held high.

// File: rtl/casc_counter.sv
module casc_stage #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         cnt,
  output logic [W-1:0] q,
  output logic         tc
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (clr)      q <= '0;
    else if (ld)  q <= ld_val;
    else if (cnt) q <= q + 1'b1;
  end

  assign tc = cnt && (q == TOP);
endmodule

module casc_counter #(
  parameter int SW = 4,
  localparam int W = 2 * SW
) (
  input  logic         clk,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         en,
  output logic [W-1:0] q,
  output logic         tc
);
  logic lo_tc;

  casc_stage #(.W(SW)) u_lo (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val[SW-1:0]),
    .cnt(en), .q(q[SW-1:0]), .tc(lo_tc)
  );

  casc_stage #(.W(SW)) u_hi (
    .clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val[W-1:SW]),
    .cnt(lo_tc), .q(q[W-1:SW]), .tc(tc)
  );
endmodule

module casc_counter_chk #(
  parameter int SW = 4,
  localparam int W = 2 * SW
) (
  input logic         clk,
  input logic         clr,
  input logic         ld,
  input logic [W-1:0] ld_val,
  input logic         en,
  input logic [W-1:0] q,
  input logic         tc
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (clr) armed <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) clr |=> q == '0); // R1
  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (!armed || clr)
    ld |=> q == $past(ld_val)); // R2
  AST_LOW_STEP: assert property (@(posedge clk) disable iff (!armed || clr)
    (en && !ld) |=> q[SW-1:0] == $past(q[SW-1:0]) + 1'b1); // R3
  AST_HIGH_ON_CARRY: assert property (@(posedge clk) disable iff (!armed || clr)
    (!ld && !(en && &q[SW-1:0])) |=> $stable(q[W-1:SW])); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!armed || clr)
    (!en && !ld) |=> $stable(q)); // R5
  AST_WRAP_AFTER_TC: assert property (@(posedge clk) disable iff (!armed || clr)
    (tc && !ld) |=> q == '0); // R6
  AST_TC_ONLY_AT_TOP: assert property (@(posedge clk) disable iff (!armed)
    tc |-> (en && &q)); // R7
endmodule

bind casc_counter casc_counter_chk #(.SW(SW)) u_chk (
  .clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val), .en(en), .q(q), .tc(tc)
);

// File: tb/casc_counter_test.sv
`timescale 1ns/1ps
module casc_counter_test;
  logic       clk = 1'b0;
  logic       clr = 1'b0, ld = 1'b0, en = 1'b0;
  logic [7:0] ld_val = 8'h00;
  logic [7:0] q;
  logic       tc;
  int checks = 0, fails = 0;
  int model = 0;
  bit done = 0;

  always #4 clk = ~clk;

  casc_counter uut (.clk(clk), .clr(clr), .ld(ld), .ld_val(ld_val), .en(en), .q(q), .tc(tc));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, check tc, clock, update model, check q at next negedge
  task automatic step(input bit c, input bit l, input int v, input bit e);
    string tag;
    int old;
    clr = c; ld = l; ld_val = v[7:0]; en = e;
    #1;
    if (!c) check("R7 tc", int'(tc), (model == 255 && e) ? 1 : 0);
    old = model;
    if (c) begin model = 0; tag = "R1 clear"; end
    else if (l) begin model = v & 255; tag = "R2 load"; end
    else if (e) begin
      model = (model + 1) % 256;
      tag = (old == 255) ? "R6 wrap" : ((old % 16) == 15) ? "R4 carry" : "R3 count";
    end
    else tag = "R5 hold";
    @(negedge clk);
    check(tag, int'(q), model);
    if (!c && !l) check("R4 upper nibble", int'(q[7:4]), model / 16);
  endtask

  initial begin
    @(negedge clk);
    step(1, 1, 8'hA5, 1);                     // R1 clear beats load and count
    check("R1 reset state", int'(q), 0);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 1);   // R3, R4 across 15->16
    step(0, 0, 0, 0); step(0, 0, 0, 0);              // R5
    step(0, 1, 8'hFE, 1);                            // R2 load beats count
    step(0, 0, 0, 1); step(0, 0, 0, 1);              // R7 at 255, R6 wrap
    step(0, 1, 8'h3F, 0); step(0, 0, 0, 1);          // R4 carry to 0x40
    step(0, 1, 8'h0F, 0); step(0, 0, 0, 0);          // R4 no carry when idle
    for (int i = 0; i < 600; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 2) step(1, 1, 8'hFF, 1);
      else if (r < 6) begin
        int pick = $urandom_range(0, 3);
        step(0, 1, (pick == 0) ? 14 : (pick == 1) ? 15 : (pick == 2) ? 254 : 255, $urandom_range(0, 1));
      end
      else step(0, 0, 0, $urandom_range(0, 3) != 0);
    end
    step(1, 0, 0, 0);
    for (int i = 0; i < 300; i++) step(0, 0, 0, 1);  // R6 full turn
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule